// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a clocked single-port memory of 32-bit words split into four byte lanes. A request offers a word address, write data and write controls. Every request input is captured on the rising clock edge. The address must already be resolved, because the block has no burst counter of its own. A write can store all four lanes with a global write, or only the selected lanes with a byte write. Any accepted request that is not a write is a read. The block takes a new request every cycle and never stalls.

Read data leaves the block in one of two ways, chosen by the run-time input `pipe_mode`. In flow-through mode (`pipe_mode` = 0) the data bypasses the output register. In pipeline mode (`pipe_mode` = 1) it passes through that register and arrives one cycle later. The output-valid indication follows single-cycle-deselect timing: a deselect turns it off in the cycle right after the deselect is captured, one stage earlier than a read turns it on. An asynchronous output enable only gates the outputs. A sleep input blocks all access and keeps the stored contents.

The request side is a valid/ready stream. `req_ready` is low only during sleep. A request counts only on an edge where `req_valid` and `req_ready` are both high. A cycle with `req_valid` low is a deselect. The read-data side has no ready input, because a memory of this kind cannot hold back its output. A consumer must take `rd_data` in every cycle where `rd_valid` is high.

Top module: `sram_burst_dp`

## Requirements
- R1: Request inputs are sampled on the rising clock edge. While `sleep` is low, `req_ready` is high and a request can be accepted on every cycle, with no stall cycles between back-to-back requests.
- R2: An accepted request with `gw_en` high stores all four lanes of `wr_data`, whatever `bw_en` and `byte_sel` are.
- R3: An accepted request with `gw_en` low, `bw_en` high and `byte_sel` nonzero stores only the lanes whose select bit is set. Lane i is bits 8i+7..8i of the word, selected by `byte_sel[i]`. All other lanes keep their old value.
- R4: An accepted request with `gw_en` low and either `bw_en` low or `byte_sel` all zero is a read. It leaves the array unchanged.
- R5: With `pipe_mode` = 0, read data for a read captured at edge k is on `rd_data`, with `rd_valid` high, between edge k and edge k+1.
- R6: With `pipe_mode` = 1, read data for a read captured at edge k is on `rd_data` between edge k+1 and edge k+2. It is not shown before edge k+1.
- R7: When an edge captures no accepted request (a deselect), `rd_valid` is low after that edge in both modes. In pipeline mode this holds even if the previous edge captured a read.
- R8: While `oe` is low, `rd_valid` and `rd_data` are zero at once, with no clock edge needed. The array and the read pipeline are unaffected, so raising `oe` shows the pending read data in the same cycle.
- R9: While `sleep` is high, `req_ready` is low, no request is accepted and the stored words are retained.
- R10: After reset, `rd_valid` is low and `rd_data` is zero.
- R11: A write never raises `rd_valid` in the cycle where its own result slot appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| pipe_mode | input | 1 | 1 selects the registered (pipeline) read path, 0 the bypass (flow-through) path |
| sleep | input | 1 | Blocks all access while high; contents are kept |
| req_valid | input | 1 | Request present; low means deselect |
| req_ready | output | 1 | Request can be accepted (low during sleep) |
| addr | input | AW | Word address |
| wr_data | input | 32 | Write data, four byte lanes |
| gw_en | input | 1 | Global write: store all lanes |
| bw_en | input | 1 | Byte write enable |
| byte_sel | input | 4 | Per-lane select for byte writes |
| oe | input | 1 | Asynchronous output enable |
| rd_data | output | 32 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data is being driven this cycle |

## Verification
The bench uses a 16-word array. It first fills every word with global writes whose lane selects vary, then reads all words back to back in flow-through mode. This separates correct global-write and flow-through behaviour from lane-select leaking or address aliasing. It then sweeps all fifteen nonzero byte masks, plus the zero-mask and no-write cases. Each mask leaves a distinct lane pattern, so a wrong lane decode or a wrongly taken write shows up. Pipelined read streams are broken by deselects, output-enable drops, sleep windows and a write that lands right behind a read. These expose an off-by-one latency, late deselect release, an output enable that disturbs state, and a read-before-write ordering error.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_req_decode.sv
module sram_req_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             req_valid,
  input  logic             sleep,
  input  logic             gw_en,
  input  logic             bw_en,
  input  logic [LANES-1:0] byte_sel,
  output logic             req_ready,
  output sram_op_e         op,
  output logic [LANES-1:0] lane_we
);
  logic [LANES-1:0] mask;
  logic             accept;

  always_comb begin
    req_ready = ~sleep;
    accept    = req_valid & ~sleep;
    if (gw_en)      mask = '1;
    else if (bw_en) mask = byte_sel;
    else            mask = '0;
    if (!accept)       op = OP_IDLE;
    else if (|mask)    op = OP_WRITE;
    else               op = OP_READ;
    lane_we = (op == OP_WRITE) ? mask : '0;
  end
endmodule

// File: rtl/sram_word_array.sv
module sram_word_array
  import sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] lane_we,
  input  logic [AW-1:0]    waddr,
  input  logic [WW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/sram_read_stage.sv
module sram_read_stage
  import sram_pkg::*;
#(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          oe,
  input  sram_op_e      op,
  input  logic [WW-1:0] arr_rdata,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid
);
  logic          rd_q;
  logic          desel_q;
  logic          rd2_q;
  logic [WW-1:0] pdata_q;
  logic          drive;
  logic [WW-1:0] data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      desel_q <= 1'b1;
      rd2_q   <= 1'b0;
      pdata_q <= '0;
    end else begin
      rd_q    <= (op == OP_READ);
      desel_q <= (op == OP_IDLE);
      rd2_q   <= rd_q;
      pdata_q <= arr_rdata;
    end
  end

  always_comb begin
    if (pipe_mode) begin
      drive    = rd2_q & ~desel_q;
      data_sel = pdata_q;
    end else begin
      drive    = rd_q;
      data_sel = arr_rdata;
    end
    rd_valid = drive & oe;
    rd_data  = rd_valid ? data_sel : '0;
  end
endmodule

// File: rtl/sram_burst_dp.sv
module sram_burst_dp
  import sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             sleep,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    addr,
  input  logic [WW-1:0]    wr_data,
  input  logic             gw_en,
  input  logic             bw_en,
  input  logic [LANES-1:0] byte_sel,
  input  logic             oe,
  output logic [WW-1:0]    rd_data,
  output logic             rd_valid
);
  sram_op_e         op;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    addr_q;
  logic [WW-1:0]    arr_rdata;

  sram_req_decode #(.LANES(LANES)) u_dec (
    .req_valid (req_valid),
    .sleep     (sleep),
    .gw_en     (gw_en),
    .bw_en     (bw_en),
    .byte_sel  (byte_sel),
    .req_ready (req_ready),
    .op        (op),
    .lane_we   (lane_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              addr_q <= '0;
    else if (op == OP_READ)  addr_q <= addr;
  end

  sram_word_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (addr),
    .wdata   (wr_data),
    .raddr   (addr_q),
    .rdata   (arr_rdata)
  );

  sram_read_stage #(.WW(WW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .op        (op),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/sram_burst_dp_chk.sv
module sram_burst_dp_chk #(
  parameter int LANES = 4,
  parameter int WW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             sleep,
  input logic             req_valid,
  input logic             req_ready,
  input logic             gw_en,
  input logic             bw_en,
  input logic [LANES-1:0] byte_sel,
  input logic             oe,
  input logic [WW-1:0]    rd_data,
  input logic             rd_valid
);
  logic acc, rd_req, wr_req;
  assign acc    = req_valid && req_ready;
  assign wr_req = acc && (gw_en || (bw_en && (byte_sel != '0)));
  assign rd_req = acc && !wr_req;

  assert_ready_awake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> req_ready);

  assert_sleep_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !req_ready);

  assert_flow_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !pipe_mode && oe) |=> ((!pipe_mode && oe) -> rd_valid));

  assert_pipe_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && pipe_mode) ##1 acc |=> ((pipe_mode && oe) -> rd_valid));

  assert_desel_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rd_valid);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!rd_valid && rd_data == '0));

  assert_write_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !pipe_mode) |=> (!pipe_mode -> !rd_valid));
endmodule

bind sram_burst_dp sram_burst_dp_chk #(.LANES(LANES), .WW(WW)) u_chk (.*);

// File: tb/sim_sram_burst_dp.sv
`timescale 1ns/1ps
module sim_sram_burst_dp;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n, pipe_mode, sleep, req_valid, gw_en, bw_en, oe;
  logic        req_ready, rd_valid;
  logic [AW-1:0] addr;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  byte_sel;
  logic [31:0] ref_mem [DEPTH];
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sram_burst_dp #(.DEPTH(DEPTH), .LANES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
    .req_valid(req_valid), .req_ready(req_ready), .addr(addr),
    .wr_data(wr_data), .gw_en(gw_en), .bw_en(bw_en), .byte_sel(byte_sel),
    .oe(oe), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] pat(int a, int s);
    return 32'(a * 32'h0103_0507 + s * 32'h1020_4081 + 32'h0F1E_2D3C);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(logic v, int a, logic [31:0] d, logic g, logic b, logic [3:0] s);
    req_valid = v; addr = AW'(a); wr_data = d; gw_en = g; bw_en = b; byte_sel = s;
    @(negedge clk);
  endtask

  task automatic rd(int a);
    req(1'b1, a, 32'h0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic idle();
    req(1'b0, 0, 32'h0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0; sleep = 1'b0; oe = 1'b1;
    req_valid = 1'b0; addr = '0; wr_data = '0; gw_en = 1'b0; bw_en = 1'b0; byte_sel = '0;
    repeat (3) @(negedge clk);
    chk("R10 valid", 32'(rd_valid), 32'd0);
    chk("R10 data", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);

    // R2: global write fill, lane selects varied
    for (int a = 0; a < DEPTH; a++) begin
      req(1'b1, a, pat(a, 0), 1'b1, a[0], 4'(a));
      ref_mem[a] = pat(a, 0);
      chk("R11 write no valid", 32'(rd_valid), 32'd0);
    end
    // R5 / R1: back-to-back flow-through reads
    for (int a = 0; a < DEPTH; a++) begin
      rd(a);
      chk("R5 valid", 32'(rd_valid), 32'd1);
      chk("R2 R5 data", rd_data, ref_mem[a]);
    end

    // R3: every nonzero lane mask
    for (int m = 1; m < 16; m++) begin
      req(1'b1, m, pat(m, 1), 1'b0, 1'b1, 4'(m));
      for (int l = 0; l < 4; l++)
        if (m[l]) ref_mem[m][l*8 +: 8] = pat(m, 1) >> (l*8);
    end
    // R4: zero mask and no write enable are reads
    req(1'b1, 0, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'h0);
    chk("R4 zero mask read", rd_data, ref_mem[0]);
    req(1'b1, 1, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'hF);
    chk("R4 no enable read", rd_data, ref_mem[1]);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a);
      chk("R3 lane merge", rd_data, ref_mem[a]);
    end

    // R6: pipeline stream
    pipe_mode = 1'b1;
    idle();
    rd(0);
    chk("R6 not early", 32'(rd_valid), 32'd0);
    for (int a = 1; a < DEPTH; a++) begin
      rd(a);
      chk("R6 valid", 32'(rd_valid), 32'd1);
      chk("R6 data", rd_data, ref_mem[a-1]);
    end
    idle();
    chk("R7 pipe deselect", 32'(rd_valid), 32'd0);
    rd(3);
    chk("R6 latency", 32'(rd_valid), 32'd0);
    rd(4);
    chk("R6 data after gap", rd_data, ref_mem[3]);

    // R7 in flow-through
    pipe_mode = 1'b0;
    rd(5);
    chk("R5 data", rd_data, ref_mem[5]);
    idle();
    chk("R7 flow deselect", 32'(rd_valid), 32'd0);

    // R8: output enable in pipeline mode
    pipe_mode = 1'b1;
    rd(6);
    oe = 1'b0;
    rd(7);
    chk("R8 valid gated", 32'(rd_valid), 32'd0);
    chk("R8 data gated", rd_data, 32'd0);
    oe = 1'b1;
    #1;
    chk("R8 restore", rd_data, ref_mem[6]);
    rd(8);
    chk("R8 pipeline kept", rd_data, ref_mem[7]);

    // R9: sleep
    pipe_mode = 1'b0;
    sleep = 1'b1;
    #1;
    chk("R9 not ready", 32'(req_ready), 32'd0);
    req(1'b1, 9, ~ref_mem[9], 1'b1, 1'b0, 4'h0);
    chk("R9 no output", 32'(rd_valid), 32'd0);
    rd(9);
    sleep = 1'b0;
    rd(9);
    chk("R9 retained", rd_data, ref_mem[9]);

    // R11 / ordering: write right behind a pipelined read
    pipe_mode = 1'b1;
    rd(10);
    req(1'b1, 10, pat(10, 7), 1'b1, 1'b0, 4'h0);
    chk("R6 old before write", rd_data, ref_mem[10]);
    ref_mem[10] = pat(10, 7);
    rd(10);
    chk("R11 write slot", 32'(rd_valid), 32'd0);
    rd(11);
    chk("R2 new data", rd_data, ref_mem[10]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule